// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block sits on the receive side of an Ethernet MAC and inspects the destination address of each incoming frame. Frame bytes arrive one per cycle, qualified by a valid strobe, with the first byte flagged as start and the last as end. The block classifies the frame as unicast, broadcast or multicast, and flags IP multicast. It then applies a basic filter: an exact unicast match, reject switches for broadcast and multicast, and four exact multicast entries. An optional extended stage follows, with a second unicast address and a 32768-bit multicast bitmap. A length rule for tagged-size frames and a runt check complete the verdict.

One cycle after the last byte, the block presents a verdict with the class flags. Accepted frames update four 64-bit statistics counters: bytes, frames, broadcast frames and multicast frames. The bitmap is loaded through a 32-bit word write port. Frame storage and data movement belong to other blocks.

Top module: `rxaddr_filter`

## Requirements
- R1: A frame whose first destination byte has bit 0 clear is unicast. A frame whose six destination bytes are all FF is broadcast. Every other frame is multicast. A multicast frame whose first three bytes are 01, 00, 52 also raises the IP-multicast flag. Exactly one of the three class flags is set in each verdict.
- R2: When promiscuous mode is off, a unicast frame passes the basic stage only if its destination equals the unicast address. Destination bytes 0 to 3, in wire order, are bits [7:0], [15:8], [23:16] and [31:24] of the low word. Bytes 4 and 5 are bits [7:0] and [15:8] of the high half-word.
- R3: When promiscuous mode is off and the broadcast-reject input is set, broadcast frames are dropped.
- R4: When promiscuous mode is off, a multicast frame is dropped if the multicast-reject input is set. It is also dropped if its destination matches none of the four multicast entries. The entries use the same byte layout as R2.
- R5: With promiscuous mode on, the basic stage of R2 to R4 passes every frame.
- R6: The extended stage applies only when both bits of the extended-enable input are 1. In that stage, a unicast frame must match the second unicast address, laid out as in R2. A broadcast frame is dropped when broadcast-reject is set.
- R7: In the extended stage, a multicast frame starting 01, 00, 52 is dropped. Any other multicast frame forms a lookup index: bits [14:8] are bits [6:0] of byte 4, and bits [7:0] are byte 5. Bits [14:5] of the index select a table word and bits [4:0] select a bit within it. The frame is dropped when that bit is 0. A table write takes effect from the next cycle, and reset clears the table.
- R8: When both the jumbo-allowed and tag-allowed inputs are 0, frames of 1519 to 1522 bytes are dropped. Lengths of 1518 and 1523 are not affected.
- R9: A frame shorter than 12 bytes that passes every other rule is not accepted and sets the runt flag in its verdict. A short frame rejected by an address rule leaves the runt flag clear.
- R10: The verdict valid output is a one-cycle pulse in the cycle after the end byte is taken. The accept and class outputs are valid with that pulse. Idle cycles inside a frame do not change the result.
- R11: In the same cycle as an accepting verdict, the byte counter grows by the frame length and the frame counter by one. The broadcast counter also grows by one for a broadcast frame, and the multicast counter by one for a multicast frame. A dropped frame leaves all counters unchanged.
- R12: Synchronous reset clears the four counters and the verdict valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| cfg_promisc | input | 1 | Bypass basic stage |
| cfg_drop_bcast | input | 1 | Reject broadcast |
| cfg_drop_mcast | input | 1 | Reject multicast in basic stage |
| cfg_ext_enable | input | 2 | Both set enables extended stage |
| cfg_jumbo_ok | input | 1 | Jumbo frames allowed |
| cfg_vlan_ok | input | 1 | Tagged-size frames allowed |
| cfg_uc_lo | input | 32 | Unicast address bytes 0-3 |
| cfg_uc_hi | input | 16 | Unicast address bytes 4-5 |
| cfg_mc_lo | input | NUM_MC x 32 | Multicast entries, bytes 0-3 |
| cfg_mc_hi | input | NUM_MC x 16 | Multicast entries, bytes 4-5 |
| cfg_xuc_lo | input | 32 | Extended unicast bytes 0-3 |
| cfg_xuc_hi | input | 16 | Extended unicast bytes 4-5 |
| tbl_wr_en | input | 1 | Bitmap word write strobe |
| tbl_wr_addr | input | 10 | Bitmap word index |
| tbl_wr_data | input | 32 | Bitmap word data |
| res_valid | output | 1 | Verdict pulse |
| res_accept | output | 1 | Frame accepted |
| res_ucast | output | 1 | Unicast class |
| res_bcast | output | 1 | Broadcast class |
| res_mcast | output | 1 | Multicast class |
| res_ipmc | output | 1 | IP multicast prefix |
| res_runt | output | 1 | Short frame reject flag |
| cnt_bytes | output | 64 | Accepted byte count |
| cnt_frames | output | 64 | Accepted frame count |
| cnt_bcast | output | 64 | Accepted broadcast count |
| cnt_mcast | output | 64 | Accepted multicast count |

## Verification
The verdict and all four counters are registered at the clock edge that takes the end byte, so they are due one cycle later. The bench drives bytes on falling edges and reads the verdict on the falling edge that follows the end byte's rising edge. It confirms that the pulse has gone on the falling edge after that. Expected counter values are kept in the bench and compared at the verdict sample point. Bitmap writes and reset complete before the next frame's first byte, which respects their one-cycle latency.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int OCTET_W    = 8;
    localparam int DA_BYTES   = 6;
    localparam int RUNT_LIMIT = 12;
    localparam int TAG_MIN    = 1519;
    localparam int TAG_MAX    = 1522;

    localparam logic [OCTET_W-1:0] IPMC_B0 = 8'h01;
    localparam logic [OCTET_W-1:0] IPMC_B1 = 8'h00;
    localparam logic [OCTET_W-1:0] IPMC_B2 = 8'h52;

    // element 0 is the first destination byte seen on the wire
    typedef logic [DA_BYTES-1:0][OCTET_W-1:0] mac_t;

    typedef struct packed {
        logic accept;
        logic ucast;
        logic bcast;
        logic mcast;
        logic ipmc;
        logic runt;
    } verdict_t;

    function automatic mac_t mac_from_words(input logic [31:0] lo, input logic [15:0] hi);
        mac_t m;
        for (int i = 0; i < 4; i++) begin
            m[i] = lo[OCTET_W*i +: OCTET_W];
        end
        m[4] = hi[7:0];
        m[5] = hi[15:8];
        return m;
    endfunction

    function automatic logic has_ipmc_prefix(input mac_t m);
        return (m[0] == IPMC_B0) && (m[1] == IPMC_B1) && (m[2] == IPMC_B2);
    endfunction

endpackage

// File: rtl/rxaf_hdr_capture.sv
module rxaf_hdr_capture
    import rxaf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [OCTET_W-1:0] in_data,
    input  logic               in_eof,
    output logic               fin,
    output logic [LEN_W-1:0]   fin_len,
    output mac_t               fin_da
);
    localparam logic [LEN_W-1:0] LEN_SAT = '1;

    logic [LEN_W-1:0] cnt_q;
    mac_t             da_q;
    logic             first;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_nx;
    mac_t             da_nx;

    always_comb begin
        first  = in_valid && in_sof;
        pos    = first ? '0 : cnt_q;
        len_nx = (pos == LEN_SAT) ? LEN_SAT : pos + 1'b1;
        da_nx  = first ? '0 : da_q;
        for (int i = 0; i < DA_BYTES; i++) begin
            if (in_valid && (pos == LEN_W'(i))) begin
                da_nx[i] = in_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            da_q  <= '0;
        end else if (in_valid) begin
            cnt_q <= len_nx;
            da_q  <= da_nx;
        end
    end

    assign fin     = in_valid && in_eof;
    assign fin_len = len_nx;
    assign fin_da  = da_nx;

endmodule

// File: rtl/rxaf_mc_table.sv
module rxaf_mc_table #(
    parameter int IDX_W  = 15,
    parameter int WORD_W = 32,
    localparam int BIT_W = $clog2(WORD_W),
    localparam int AW    = IDX_W - BIT_W,
    localparam int WORDS = 2 ** AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_bit
);
    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem[rd_idx[IDX_W-1:BIT_W]];
    assign rd_bit  = rd_word[rd_idx[BIT_W-1:0]];

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int NUM_MC = 4,
    parameter int IDX_W  = 15
) (
    input  mac_t                    da,
    input  logic [LEN_W-1:0]        len,
    input  logic                    promisc,
    input  logic                    drop_bcast,
    input  logic                    drop_mcast,
    input  logic [1:0]              ext_enable,
    input  logic                    jumbo_ok,
    input  logic                    vlan_ok,
    input  logic [31:0]             uc_lo,
    input  logic [15:0]             uc_hi,
    input  logic [NUM_MC-1:0][31:0] mc_lo,
    input  logic [NUM_MC-1:0][15:0] mc_hi,
    input  logic [31:0]             xuc_lo,
    input  logic [15:0]             xuc_hi,
    input  logic                    tbl_bit,
    output logic [IDX_W-1:0]        tbl_idx,
    output verdict_t                vd
);
    logic              is_uc;
    logic              is_bc;
    logic              is_mc;
    logic              prefix;
    logic [NUM_MC-1:0] mc_hits;
    logic              basic_ok;
    logic              ext_ok;
    logic              size_ok;
    logic              short_frm;
    logic              pass;

    for (genvar k = 0; k < NUM_MC; k++) begin : g_mc_entry
        assign mc_hits[k] = (da == mac_from_words(mc_lo[k], mc_hi[k]));
    end

    assign tbl_idx = IDX_W'({da[4], da[5]});

    always_comb begin
        is_uc  = ~da[0][0];
        is_bc  = &da;
        is_mc  = !is_uc && !is_bc;
        prefix = has_ipmc_prefix(da);

        if (promisc)    basic_ok = 1'b1;
        else if (is_uc) basic_ok = (da == mac_from_words(uc_lo, uc_hi));
        else if (is_bc) basic_ok = !drop_bcast;
        else            basic_ok = !drop_mcast && (|mc_hits);

        if (!(&ext_enable)) ext_ok = 1'b1;
        else if (is_uc)     ext_ok = (da == mac_from_words(xuc_lo, xuc_hi));
        else if (is_bc)     ext_ok = !drop_bcast;
        else                ext_ok = !prefix && tbl_bit;

        size_ok   = jumbo_ok || vlan_ok ||
                    !((len >= LEN_W'(TAG_MIN)) && (len <= LEN_W'(TAG_MAX)));
        short_frm = len < LEN_W'(RUNT_LIMIT);
        pass      = size_ok && basic_ok && ext_ok;

        vd.accept = pass && !short_frm;
        vd.runt   = pass && short_frm;
        vd.ucast  = is_uc;
        vd.bcast  = is_bc;
        vd.mcast  = is_mc;
        vd.ipmc   = is_mc && prefix;
    end

endmodule

// File: rtl/rxaf_stats.sv
module rxaf_stats #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [LEN_W-1:0] len,
    input  logic             is_bc,
    input  logic             is_mc,
    output logic [CNT_W-1:0] bytes_q,
    output logic [CNT_W-1:0] frames_q,
    output logic [CNT_W-1:0] bcast_q,
    output logic [CNT_W-1:0] mcast_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q  <= '0;
            frames_q <= '0;
            bcast_q  <= '0;
            mcast_q  <= '0;
        end else if (upd) begin
            bytes_q  <= bytes_q + CNT_W'(len);
            frames_q <= frames_q + 1'b1;
            if (is_bc) bcast_q <= bcast_q + 1'b1;
            if (is_mc) mcast_q <= mcast_q + 1'b1;
        end
    end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
    import rxaf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 64,
    parameter int NUM_MC  = 4,
    parameter int IDX_W   = 15,
    parameter int WORD_W  = 32,
    localparam int TBL_AW = IDX_W - $clog2(WORD_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [OCTET_W-1:0]      in_data,
    input  logic                    cfg_promisc,
    input  logic                    cfg_drop_bcast,
    input  logic                    cfg_drop_mcast,
    input  logic [1:0]              cfg_ext_enable,
    input  logic                    cfg_jumbo_ok,
    input  logic                    cfg_vlan_ok,
    input  logic [31:0]             cfg_uc_lo,
    input  logic [15:0]             cfg_uc_hi,
    input  logic [NUM_MC-1:0][31:0] cfg_mc_lo,
    input  logic [NUM_MC-1:0][15:0] cfg_mc_hi,
    input  logic [31:0]             cfg_xuc_lo,
    input  logic [15:0]             cfg_xuc_hi,
    input  logic                    tbl_wr_en,
    input  logic [TBL_AW-1:0]       tbl_wr_addr,
    input  logic [WORD_W-1:0]       tbl_wr_data,
    output logic                    res_valid,
    output logic                    res_accept,
    output logic                    res_ucast,
    output logic                    res_bcast,
    output logic                    res_mcast,
    output logic                    res_ipmc,
    output logic                    res_runt,
    output logic [CNT_W-1:0]        cnt_bytes,
    output logic [CNT_W-1:0]        cnt_frames,
    output logic [CNT_W-1:0]        cnt_bcast,
    output logic [CNT_W-1:0]        cnt_mcast
);
    logic             fin;
    logic [LEN_W-1:0] fin_len;
    mac_t             fin_da;
    logic [IDX_W-1:0] tbl_idx;
    logic             tbl_bit;
    verdict_t         vd;
    verdict_t         res_q;
    logic             res_valid_q;

    rxaf_hdr_capture #(.LEN_W(LEN_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_data (in_data),
        .in_eof  (in_eof),
        .fin     (fin),
        .fin_len (fin_len),
        .fin_da  (fin_da)
    );

    rxaf_mc_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_wr_en),
        .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data),
        .rd_idx (tbl_idx),
        .rd_bit (tbl_bit)
    );

    rxaf_decide #(.LEN_W(LEN_W), .NUM_MC(NUM_MC), .IDX_W(IDX_W)) u_dec (
        .da        (fin_da),
        .len       (fin_len),
        .promisc   (cfg_promisc),
        .drop_bcast(cfg_drop_bcast),
        .drop_mcast(cfg_drop_mcast),
        .ext_enable(cfg_ext_enable),
        .jumbo_ok  (cfg_jumbo_ok),
        .vlan_ok   (cfg_vlan_ok),
        .uc_lo     (cfg_uc_lo),
        .uc_hi     (cfg_uc_hi),
        .mc_lo     (cfg_mc_lo),
        .mc_hi     (cfg_mc_hi),
        .xuc_lo    (cfg_xuc_lo),
        .xuc_hi    (cfg_xuc_hi),
        .tbl_bit   (tbl_bit),
        .tbl_idx   (tbl_idx),
        .vd        (vd)
    );

    rxaf_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst     (rst),
        .upd     (fin && vd.accept),
        .len     (fin_len),
        .is_bc   (vd.bcast),
        .is_mc   (vd.mcast),
        .bytes_q (cnt_bytes),
        .frames_q(cnt_frames),
        .bcast_q (cnt_bcast),
        .mcast_q (cnt_mcast)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q <= 1'b0;
            res_q       <= '0;
        end else begin
            res_valid_q <= fin;
            if (fin) res_q <= vd;
        end
    end

    assign res_valid  = res_valid_q;
    assign res_accept = res_q.accept;
    assign res_ucast  = res_q.ucast;
    assign res_bcast  = res_q.bcast;
    assign res_mcast  = res_q.mcast;
    assign res_ipmc   = res_q.ipmc;
    assign res_runt   = res_q.runt;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eof,
    input logic             res_valid,
    input logic             res_accept,
    input logic             res_ucast,
    input logic             res_bcast,
    input logic             res_mcast,
    input logic             res_ipmc,
    input logic             res_runt,
    input logic [CNT_W-1:0] cnt_bytes,
    input logic [CNT_W-1:0] cnt_frames,
    input logic [CNT_W-1:0] cnt_bcast,
    input logic [CNT_W-1:0] cnt_mcast
);
    AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid && in_eof)) else $error("verdict without end byte"); // R10

    AST_END_GIVES_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> res_valid) else $error("end byte without verdict"); // R10

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_ucast, res_bcast, res_mcast}) == 1)) else $error("class flags"); // R1

    AST_IPMC_IS_MCAST: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ipmc) |-> res_mcast) else $error("ip multicast not multicast"); // R1

    AST_RUNT_NOT_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_runt) |-> !res_accept) else $error("runt accepted"); // R9

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_accept) |-> (cnt_frames == $past(cnt_frames) + 1'b1)) else $error("frame count step"); // R11

    AST_BCAST_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_accept && res_bcast) |-> (cnt_bcast == $past(cnt_bcast) + 1'b1)) else $error("bcast count step"); // R11

    AST_MCAST_STEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_accept && res_mcast) |-> (cnt_mcast == $past(cnt_mcast) + 1'b1)) else $error("mcast count step"); // R11

    AST_DROP_HOLDS_COUNTS: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_accept) |-> ($stable(cnt_frames) && $stable(cnt_bytes))) else $error("counts moved"); // R11

endmodule

bind rxaddr_filter rxaf_checker #(.CNT_W(CNT_W)) u_rxaf_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eof    (in_eof),
    .res_valid (res_valid),
    .res_accept(res_accept),
    .res_ucast (res_ucast),
    .res_bcast (res_bcast),
    .res_mcast (res_mcast),
    .res_ipmc  (res_ipmc),
    .res_runt  (res_runt),
    .cnt_bytes (cnt_bytes),
    .cnt_frames(cnt_frames),
    .cnt_bcast (cnt_bcast),
    .cnt_mcast (cnt_mcast)
);

// File: tb/rxaddr_filter_bench.sv
module rxaddr_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_MC     = 4;
    localparam int TBL_AW     = 10;
    localparam int WD_CYCLES  = 150000;

    // cfg field order: promisc, drop_bcast, drop_mcast, ext (both bits), jumbo, vlan
    // exp field order: accept, ucast, bcast, mcast, ipmc, runt
    typedef struct packed {
        logic [47:0] da;
        logic [15:0] len;
        logic [5:0]  cfg;
        logic [5:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{48'h021122334455, 16'd64,   6'b000011, 6'b110000, 8'd2},  // R2 match
        '{48'h021122334456, 16'd64,   6'b000011, 6'b010000, 8'd2},  // R2 mismatch
        '{48'hFFFFFFFFFFFF, 16'd64,   6'b000011, 6'b101000, 8'd3},  // R3 allowed
        '{48'hFFFFFFFFFFFF, 16'd64,   6'b010011, 6'b001000, 8'd3},  // R3 rejected
        '{48'hFFFFFFFFFFFF, 16'd64,   6'b110011, 6'b101000, 8'd5},  // R5 promisc beats reject
        '{48'h0180C2000000, 16'd64,   6'b000011, 6'b100100, 8'd4},  // R4 entry hit
        '{48'h0180C2000007, 16'd64,   6'b000011, 6'b000100, 8'd4},  // R4 no entry
        '{48'h0180C2000000, 16'd64,   6'b001011, 6'b000100, 8'd4},  // R4 reject bit
        '{48'h010052000001, 16'd64,   6'b000011, 6'b100110, 8'd1},  // R1 ip multicast flag
        '{48'h021122334456, 16'd64,   6'b100011, 6'b110000, 8'd5},  // R5 any unicast
        '{48'h02AABBCCDDEE, 16'd64,   6'b100111, 6'b110000, 8'd6},  // R6 ext unicast match
        '{48'h021122334455, 16'd64,   6'b100111, 6'b010000, 8'd6},  // R6 basic addr not ext
        '{48'h333300001234, 16'd64,   6'b100111, 6'b100100, 8'd7},  // R7 bit set
        '{48'h333300001235, 16'd64,   6'b100111, 6'b000100, 8'd7},  // R7 bit clear
        '{48'h010052000001, 16'd64,   6'b100111, 6'b000110, 8'd7},  // R7 prefix dropped
        '{48'hFFFFFFFFFFFF, 16'd64,   6'b100111, 6'b101000, 8'd6},  // R6 bcast pass
        '{48'hFFFFFFFFFFFF, 16'd64,   6'b110111, 6'b001000, 8'd6},  // R6 bcast reject
        '{48'h333300001235, 16'd64,   6'b100011, 6'b100100, 8'd6},  // R6 ext off
        '{48'h021122334455, 16'd1520, 6'b000000, 6'b010000, 8'd8},  // R8 dropped
        '{48'h021122334455, 16'd1520, 6'b000010, 6'b110000, 8'd8},  // R8 jumbo
        '{48'h021122334455, 16'd1520, 6'b000001, 6'b110000, 8'd8},  // R8 tag
        '{48'h021122334455, 16'd1518, 6'b000000, 6'b110000, 8'd8},  // R8 below
        '{48'h021122334455, 16'd1523, 6'b000000, 6'b110000, 8'd8},  // R8 above
        '{48'h021122334455, 16'd1519, 6'b000000, 6'b010000, 8'd8},  // R8 low edge
        '{48'h021122334455, 16'd1522, 6'b000000, 6'b010000, 8'd8},  // R8 high edge
        '{48'h021122334455, 16'd11,   6'b000011, 6'b010001, 8'd9},  // R9 runt flag
        '{48'h021122334455, 16'd12,   6'b000011, 6'b110000, 8'd9},  // R9 minimum ok
        '{48'h021122334456, 16'd11,   6'b000011, 6'b010000, 8'd9},  // R9 addr drop no flag
        '{48'h333300008000, 16'd64,   6'b100111, 6'b100100, 8'd7},  // R7 word 0 bit 0
        '{48'h333300007FFF, 16'd64,   6'b100111, 6'b100100, 8'd7},  // R7 last word bit 31
        '{48'h333300007FFE, 16'd64,   6'b100111, 6'b000100, 8'd7}   // R7 last word bit 30
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                    in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0]              in_data = 0;
    logic                    cfg_promisc = 0, cfg_drop_bcast = 0, cfg_drop_mcast = 0;
    logic [1:0]              cfg_ext_enable = 0;
    logic                    cfg_jumbo_ok = 1, cfg_vlan_ok = 1;
    logic [31:0]             cfg_uc_lo = 32'h33221102;
    logic [15:0]             cfg_uc_hi = 16'h5544;
    logic [NUM_MC-1:0][31:0] cfg_mc_lo;
    logic [NUM_MC-1:0][15:0] cfg_mc_hi;
    logic [31:0]             cfg_xuc_lo = 32'hCCBBAA02;
    logic [15:0]             cfg_xuc_hi = 16'hEEDD;
    logic                    tbl_wr_en = 0;
    logic [TBL_AW-1:0]       tbl_wr_addr = 0;
    logic [31:0]             tbl_wr_data = 0;
    logic res_valid, res_accept, res_ucast, res_bcast, res_mcast, res_ipmc, res_runt;
    logic [63:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

    int total = 0;
    int bad = 0;
    logic [63:0] e_bytes = 0, e_frames = 0, e_bc = 0, e_mc = 0;

    rxaddr_filter u_rxaddr_filter (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .cfg_promisc(cfg_promisc), .cfg_drop_bcast(cfg_drop_bcast),
        .cfg_drop_mcast(cfg_drop_mcast), .cfg_ext_enable(cfg_ext_enable),
        .cfg_jumbo_ok(cfg_jumbo_ok), .cfg_vlan_ok(cfg_vlan_ok),
        .cfg_uc_lo(cfg_uc_lo), .cfg_uc_hi(cfg_uc_hi),
        .cfg_mc_lo(cfg_mc_lo), .cfg_mc_hi(cfg_mc_hi),
        .cfg_xuc_lo(cfg_xuc_lo), .cfg_xuc_hi(cfg_xuc_hi),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .res_valid(res_valid), .res_accept(res_accept), .res_ucast(res_ucast),
        .res_bcast(res_bcast), .res_mcast(res_mcast), .res_ipmc(res_ipmc),
        .res_runt(res_runt),
        .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
        .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_cfg(input logic [5:0] c);
        cfg_promisc    = c[5];
        cfg_drop_bcast = c[4];
        cfg_drop_mcast = c[3];
        cfg_ext_enable = {2{c[2]}};
        cfg_jumbo_ok   = c[1];
        cfg_vlan_ok    = c[0];
    endtask

    task automatic tbl_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = TBL_AW'(addr);
        tbl_wr_data = data;
        @(negedge clk);
        tbl_wr_en   = 1'b0;
    endtask

    // drives one frame; on return the verdict pulse is visible (one cycle after the end byte)
    task automatic send_frame(input logic [47:0] da, input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
            if (gaps && i < len - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic expect_frame(input logic [5:0] exp, input int len, input string req);
        logic [5:0] got;
        got = {res_accept, res_ucast, res_bcast, res_mcast, res_ipmc, res_runt};
        check(res_valid === 1'b1, {req, " R10 pulse"}, 64'(res_valid), 64'd1);
        check(got === exp, {req, " verdict"}, 64'(got), 64'(exp));
        if (exp[5]) begin
            e_bytes  += 64'(len);
            e_frames += 1;
            if (exp[3]) e_bc += 1;
            if (exp[2]) e_mc += 1;
        end
        check(cnt_bytes == e_bytes,   {req, " R11 bytes"},  cnt_bytes,  e_bytes);
        check(cnt_frames == e_frames, {req, " R11 frames"}, cnt_frames, e_frames);
        check(cnt_bcast == e_bc,      {req, " R11 bcast"},  cnt_bcast,  e_bc);
        check(cnt_mcast == e_mc,      {req, " R11 mcast"},  cnt_mcast,  e_mc);
        @(negedge clk);
        check(res_valid === 1'b0, {req, " R10 single pulse"}, 64'(res_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=done", WD_CYCLES);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_mc_lo[0] = 32'h00C28001; cfg_mc_hi[0] = 16'h0000;
        cfg_mc_lo[1] = 32'h00C28001; cfg_mc_hi[1] = 16'h0E00;
        cfg_mc_lo[2] = 32'h005E0001; cfg_mc_hi[2] = 16'hFB00;
        cfg_mc_lo[3] = 32'h00520001; cfg_mc_hi[3] = 16'h0100;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(res_valid === 1'b0, "R12 valid", 64'(res_valid), 0);
        check(cnt_bytes == 0 && cnt_frames == 0 && cnt_bcast == 0 && cnt_mcast == 0,
              "R12 counters", cnt_frames, 0);

        // R7 bitmap: index 0x1234 -> word 145 bit 20; index 0 -> word 0 bit 0; 0x7FFF -> word 1023 bit 31
        tbl_write(145, 32'h0010_0000);
        tbl_write(0, 32'h0000_0001);
        tbl_write(1023, 32'h8000_0000);

        for (int v = 0; v < NV; v++) begin
            apply_cfg(VECS[v].cfg);
            send_frame(VECS[v].da, int'(VECS[v].len), 1'b0);
            expect_frame(VECS[v].exp, int'(VECS[v].len), $sformatf("R%0d vec%0d", VECS[v].req, v));
        end

        // R6: a single extended-enable bit leaves the stage off
        apply_cfg(6'b100011);
        cfg_ext_enable = 2'b01;
        send_frame(48'h333300001235, 64, 1'b0);
        expect_frame(6'b100100, 64, "R6 one bit low");
        cfg_ext_enable = 2'b10;
        send_frame(48'h333300001235, 64, 1'b0);
        expect_frame(6'b100100, 64, "R6 one bit high");

        // R10: idle cycles inside the frame
        apply_cfg(6'b000011);
        send_frame(48'h021122334455, 20, 1'b1);
        expect_frame(6'b110000, 20, "R10 gapped");

        // R12 mid-run reset, then R7 bitmap cleared by reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        e_bytes = 0; e_frames = 0; e_bc = 0; e_mc = 0;
        check(cnt_bytes == 0 && cnt_frames == 0 && cnt_bcast == 0 && cnt_mcast == 0,
              "R12 counters after reset", cnt_bytes, 0);
        apply_cfg(6'b100111);
        send_frame(48'h333300001234, 64, 1'b0);
        expect_frame(6'b000100, 64, "R7 table cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule